// File: doc/BRIEF.md
# Module Identity I2C EEPROM Slave

This block sits on a memory module and answers a two-wire serial bus with the contents of a 256-byte store. The lower half of the store describes the module (its organisation and timing). The upper half is free for system use. The block samples the bus clock and data lines with its own system clock, after a two-flop synchronizer. It recognises start and stop conditions and compares the first byte of each transfer with its device address. That address carries a fixed type code and the value of three strap pins, so eight such devices can share one bus.

A write transfer loads the internal word pointer from its second byte. Each later byte is stored at the pointer, and the pointer then advances. A read transfer returns bytes from the pointer for as long as the master acknowledges. A stop that closes a write which stored at least one byte starts a program cycle. For that many clocks the block refuses to acknowledge its own address. A write-protect input blocks storing, but the handshake on the bus is unchanged. The data line is open-drain. The block only ever pulls it low, through a drive-enable output.

The bus interface is a plain pin-level protocol with no valid/ready handshake. The master sets the pace through the clock line. The block never stretches the clock, so there is no back-pressure on either side.

Top module: `modid_eeprom_slave`

## Requirements
- R1: After reset, and until a start condition is seen, `sda_low_o` stays low. Clock and data activity without a start gets no acknowledge.
- R2: A start condition (SDA falling while SCL is high) begins reception of an address byte from any state. This includes a repeated start in the middle of a transfer.
- R3: A stop condition (SDA rising while SCL is high) returns the block to idle and releases SDA.
- R4: The first byte after a start is compared as follows: bits 7..4 must equal 4'b1010, bits 3..1 must equal `strap_i[2:0]`, and bit 0 selects the direction (1 = read). On a match the block pulls SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next start.
- R5: In a write, the byte after the address loads the word pointer. Each further byte is acknowledged, stored at the pointer, and followed by a pointer increment.
- R6: In a read, bytes are sent MSB first from the pointer, and the pointer advances after each byte. An acknowledge from the master (SDA low in the ninth clock) continues the read. A no-acknowledge makes the block release SDA and wait for a stop.
- R7: A stop that ends a transfer in which at least one byte was stored starts a program cycle of `PROG_CYCLES` clocks. During that cycle the device address is not acknowledged. After it ends, the address is acknowledged again.
- R8: The word pointer wraps from 255 to 0, for both reads and writes.
- R9: While `wp_i` is high, data bytes are still acknowledged, but the store is not modified and no program cycle follows.
- R10: After reset, byte i of the store holds i XOR `INIT_SEED`, which is 8'hA5 by default.
- R11: The block asserts its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial bus clock as seen on the pad |
| sda_i | input | 1 | Serial bus data as seen on the pad |
| strap_i | input | 3 | Address strap pins |
| wp_i | input | 1 | Write protect, high blocks storing (synchronous to clk) |
| sda_low_o | output | 1 | Open-drain enable: high pulls SDA low |

## Verification
Two events can fall close together. The stop that closes a write also arms the program-cycle timer, so an address probe that follows at once lands inside the busy window. The bench issues that probe straight after the stop and expects a no-acknowledge. It then waits past the window and expects the same probe to be acknowledged. A second overlap occurs when a write transfer ends in a repeated start: the start arrives while a data byte is half-received. The bench checks that no partial byte is stored, by reading the following locations back against its arithmetic model of the store.

// File: rtl/modid_eeprom_pkg.sv
package modid_eeprom_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WORD,
    ST_WORD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_WAIT_STOP
  } slave_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam logic [3:0] BYTE_BITS = 4'd8;

endpackage

// File: rtl/modid_bus_sync.sv
module modid_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [1:0] pipe_q [STAGES];
  logic [1:0] prev_q;
  logic       scl_p;
  logic       sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) pipe_q[k] <= 2'b11;
      prev_q <= 2'b11;
    end else begin
      pipe_q[0] <= {scl_i, sda_i};
      for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign scl_s     = pipe_q[STAGES-1][1];
  assign sda_s     = pipe_q[STAGES-1][0];
  assign scl_p     = prev_q[1];
  assign sda_p     = prev_q[0];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det) && !(scl_rise && scl_fall)); // R2

endmodule

// File: rtl/modid_byte_store.sv
module modid_byte_store #(
  parameter int          DEPTH = 256,
  parameter int          DW    = 8,
  parameter logic [7:0]  SEED  = 8'hA5,
  localparam int         AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cells[g] <= DW'(g) ^ DW'(SEED);
      else if (we_i && (waddr_i == AW'(g)))
        cells[g] <= wdata_i;
    end
  end

  assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/modid_prog_timer.sv
module modid_prog_timer #(
  parameter int CYCLES = 3000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic busy_o
);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      left_q <= '0;
    else if (arm_i)
      left_q <= CW'(CYCLES);
    else if (left_q != '0)
      left_q <= left_q - 1'b1;
  end

  assign busy_o = (left_q != '0);

  AST_BUSY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(arm_i)); // R7

endmodule

// File: rtl/modid_eeprom_slave.sv
module modid_eeprom_slave #(
  parameter int         MEM_BYTES   = 256,
  parameter int         PROG_CYCLES = 3000,
  parameter logic [7:0] INIT_SEED   = 8'hA5,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(MEM_BYTES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_low_o
);
  import modid_eeprom_pkg::*;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, arm_prog;

  slave_state_e  state_q;
  logic [3:0]    cnt_q;
  logic [7:0]    shift_q;
  logic [AW-1:0] ptr_q;
  logic          sda_low_q;
  logic          rnw_q;
  logic          wr_pend_q;
  logic          mack_q;
  logic          mem_we;
  logic [7:0]    mem_rdata;
  logic          addr_hit;
  logic          byte_in;

  modid_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  modid_byte_store #(.DEPTH(MEM_BYTES), .DW(8), .SEED(INIT_SEED)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mem_we),
    .waddr_i (ptr_q),
    .wdata_i (shift_q),
    .raddr_i (ptr_q),
    .rdata_o (mem_rdata)
  );

  modid_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (arm_prog),
    .busy_o (busy)
  );

  assign addr_hit = (shift_q[7:1] == {DEV_TYPE, strap_i});
  assign byte_in  = scl_fall && (cnt_q == BYTE_BITS) && !start_det && !stop_det;
  assign mem_we   = (state_q == ST_WDATA) && byte_in && !wp_i;
  assign arm_prog = stop_det && wr_pend_q;
  assign sda_low_o = sda_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      shift_q   <= '0;
      ptr_q     <= '0;
      sda_low_q <= 1'b0;
      rnw_q     <= 1'b0;
      wr_pend_q <= 1'b0;
      mack_q    <= 1'b0;
    end else if (stop_det) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sda_low_q <= 1'b0;
      wr_pend_q <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_ADDR;
      cnt_q     <= '0;
      sda_low_q <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_WORD, ST_WDATA: begin
          if (scl_rise && (cnt_q != BYTE_BITS)) begin
            shift_q <= {shift_q[6:0], sda_s};
            cnt_q   <= cnt_q + 1'b1;
          end else if (byte_in) begin
            cnt_q <= '0;
            if (state_q == ST_ADDR) begin
              if (addr_hit && !busy) begin
                sda_low_q <= 1'b1;
                rnw_q     <= shift_q[0];
                state_q   <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_WORD) begin
              ptr_q     <= shift_q[AW-1:0];
              sda_low_q <= 1'b1;
              state_q   <= ST_WORD_ACK;
            end else begin
              ptr_q     <= ptr_q + 1'b1;
              wr_pend_q <= wr_pend_q | !wp_i;
              sda_low_q <= 1'b1;
              state_q   <= ST_WDATA_ACK;
            end
          end
        end
        ST_WORD_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            sda_low_q <= 1'b0;
            state_q   <= ST_WDATA;
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rnw_q) begin
              shift_q   <= mem_rdata;
              sda_low_q <= ~mem_rdata[7];
              ptr_q     <= ptr_q + 1'b1;
              state_q   <= ST_RDATA;
            end else begin
              sda_low_q <= 1'b0;
              state_q   <= ST_WORD;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              cnt_q     <= '0;
              sda_low_q <= 1'b0;
              state_q   <= ST_RDATA_ACK;
            end else begin
              cnt_q     <= cnt_q + 1'b1;
              shift_q   <= {shift_q[6:0], 1'b0};
              sda_low_q <= ~shift_q[6];
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              shift_q   <= mem_rdata;
              sda_low_q <= ~mem_rdata[7];
              ptr_q     <= ptr_q + 1'b1;
              state_q   <= ST_RDATA;
            end else begin
              state_q <= ST_WAIT_STOP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_low_q); // R1
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_ADDR) && (cnt_q == 4'd0)); // R2
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE) && !sda_low_q); // R3
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR_ACK) |-> !busy); // R7
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ptr_q == $past(ptr_q) + 1'b1); // R8
  AST_PULL_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_q) |-> !scl_s); // R11

endmodule

// File: tb/modid_eeprom_slave_tb.sv
`timescale 1ns/1ps
module modid_eeprom_slave_tb_top;

  localparam int         PROG  = 3000;
  localparam logic [7:0] SEED  = 8'hA5;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] AW_B  = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] AR_B  = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic sda_low_o;
  logic sda_line;
  int   tests = 0;
  int   fails = 0;
  int   r11_viol = 0;
  logic done = 1'b0;
  logic [7:0] model [256];

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_low_o;

  modid_eeprom_slave #(.PROG_CYCLES(PROG), .INIT_SEED(SEED)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .strap_i   (STRAP),
    .wp_i      (wp),
    .sda_low_o (sda_low_o)
  );

  // R11: the pull-down must never begin while SCL is high
  logic low_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_low_o && !low_prev && m_scl) r11_viol++;
    low_prev <= sda_low_o;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(8);
    m_scl = 1'b1; tick(8);
    m_sda = 1'b0; tick(8);
    m_scl = 1'b0; tick(8);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(8);
    m_scl = 1'b1; tick(8);
    m_sda = 1'b1; tick(16);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    m_sda = b;    tick(8);
    m_scl = 1'b1; tick(8);
    s = sda_line; tick(8);
    m_scl = 1'b0; tick(8);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      d[i] = s;
    end
    bus_bit(~give_ack, s);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    bus_start();
    put_byte(AW_B, a); chk(a, "R4 write address ack", a, 1);
    put_byte(p, a);    chk(a, "R5 pointer byte ack", a, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    logic [7:0] wbase;
    for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ SEED;
    tick(10);
    rst_n = 1'b1;
    tick(10);
    chk(sda_low_o == 1'b0, "R1 reset release", sda_low_o, 0);

    // R1: matching address clocked without a start
    m_scl = 1'b0; tick(8);
    put_byte(AR_B, a);
    chk(!a, "R1 no start no ack", a, 0);
    bus_stop();

    // R4: strap mismatch
    bus_start();
    put_byte({4'b1010, 3'b010, 1'b1}, a);
    chk(!a, "R4 strap mismatch nack", a, 0);
    bus_stop();

    // R10 R6 R8: full sweep from 0 with wrap, R2 repeated start
    set_ptr(8'h00);
    bus_start();
    put_byte(AR_B, a); chk(a, "R2 repeated start read ack", a, 1);
    for (int i = 0; i < 257; i++) begin
      get_byte(i < 256, d);
      if (i < 256) chk(d == model[i], "R10 reset contents", d, model[i]);
      else         chk(d == model[0], "R8 read wrap to 0", d, model[0]);
    end
    tick(4);
    chk(sda_low_o == 1'b0, "R6 release after nack", sda_low_o, 0);
    bus_stop();
    chk(sda_low_o == 1'b0, "R3 idle after stop", sda_low_o, 0);

    // R5 R8: write across the top, then cut by a repeated start mid-byte
    wbase = 8'hFD;
    set_ptr(wbase);
    for (int i = 0; i < 5; i++) begin
      put_byte(8'(i * 7 + 3), a);
      chk(a, "R5 data ack", a, 1);
      model[8'(wbase + 8'(i))] = 8'(i * 7 + 3);
    end
    m_sda = 1'b0; tick(8); m_scl = 1'b1; tick(8); m_scl = 1'b0; tick(8); // partial bit
    bus_start();
    put_byte(8'hFF, a);
    bus_stop();

    // R7: probe inside the program cycle, then after it
    bus_start();
    put_byte(AW_B, a);
    chk(!a, "R7 busy nack", a, 0);
    bus_stop();
    tick(PROG + 100);
    set_ptr(wbase);
    bus_start();
    put_byte(AR_B, a); chk(a, "R7 ack after window", a, 1);
    for (int i = 0; i < 6; i++) begin
      get_byte(i < 5, d);
      chk(d == model[8'(wbase + 8'(i))], "R8 write wrap readback", d, model[8'(wbase + 8'(i))]);
    end
    bus_stop();

    // R9: write protect
    wp = 1'b1;
    set_ptr(8'h40);
    for (int i = 0; i < 3; i++) begin
      put_byte(8'h11, a);
      chk(a, "R9 protected data ack", a, 1);
    end
    bus_stop();
    bus_start();
    put_byte(AW_B, a);
    chk(a, "R9 no program cycle", a, 1);
    bus_stop();
    wp = 1'b0;
    set_ptr(8'h40);
    bus_start();
    put_byte(AR_B, a);
    for (int i = 0; i < 3; i++) begin
      get_byte(i < 2, d);
      chk(d == model[8'h40 + i], "R9 store unchanged", d, model[8'h40 + i]);
    end
    bus_stop();

    // R6: current-address read continues from the pointer
    bus_start();
    put_byte(AR_B, a);
    get_byte(1'b0, d);
    chk(d == model[8'h43], "R6 current address read", d, model[8'h43]);
    bus_stop();

    chk(r11_viol == 0, "R11 pull only while SCL low", r11_viol, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule